// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the meeting point between a host bus and a small embedded keyboard processor. The host side sees two byte locations, chosen by a single address line. Host writes go to either location and land in one inbound byte register. The address line is recorded as a command/data marker. Host reads return either the outbound byte or a status byte. The local processor has its own strobes. It takes the inbound byte, posts an outbound byte, updates the free status bits and programs two interrupt enables.

Two full flags follow the traffic with no software involvement. The inbound flag sets on every host write and clears when the processor takes the byte. The outbound flag sets when the processor posts a byte and clears when the host takes it. Each flag drives an interrupt line through its own enable bit. A host write that arrives while the processor reports it is stopped also raises a one-cycle wake request.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset, the status byte, both data registers, both interrupt enables, `kirq`, `ibf_irq` and `wake_req` are all zero.
- R2: A host write (`host_cs` and `host_wr` high at a clock edge) loads `host_wdata` into the inbound register, shown on `cpu_in_data`, and sets the inbound-full flag, status bit 1, from the next cycle on.
- R3: On every host write, status bit 3 (the command marker) takes the value of `host_addr`: 1 for a command and 0 for data.
- R4: `cpu_in_rd` clears the inbound-full flag. If a host write occurs in the same cycle, the write wins and the flag stays set.
- R5: `cpu_out_wr` loads `cpu_wdata` into the outbound register and sets the outbound-full flag, status bit 0. The host reads that register with `host_addr` = 0.
- R6: A host read with `host_addr` = 0 clears the outbound-full flag. A host read with `host_addr` = 1 returns the status byte and leaves the flag as it is. A `cpu_out_wr` in the same cycle wins, and the flag stays set.
- R7: `kirq` is high exactly while the outbound-full flag and the host interrupt enable (bit 0 of a `cpu_ctrl_wr` write) are both set. It drops in the same cycle that a host read clears the flag.
- R8: `ibf_irq` is high exactly while the inbound-full flag and the processor interrupt enable (bit 1 of a `cpu_ctrl_wr` write) are both set.
- R9: `cpu_stat_wr` updates status bits 7, 6, 5, 4 and 2 from `cpu_wdata`. Data written to bits 0, 1 and 3 is ignored.
- R10: A host write while `cpu_stopped` is high gives a one-cycle `wake_req` pulse in the following cycle. A host write while `cpu_stopped` is low gives no pulse.
- R11: Host read and write strobes have no effect while `host_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | 1 | 0 selects data, 1 selects command/status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Outbound byte (addr 0) or status (addr 1) |
| cpu_in_rd | input | 1 | Processor takes the inbound byte |
| cpu_out_wr | input | 1 | Processor posts an outbound byte |
| cpu_stat_wr | input | 1 | Processor writes the free status bits |
| cpu_ctrl_wr | input | 1 | Processor writes the interrupt enables |
| cpu_wdata | input | 8 | Processor write data |
| cpu_in_data | output | 8 | Inbound byte |
| cpu_status | output | 8 | Status byte as the processor sees it |
| cpu_stopped | input | 1 | Processor is in its stopped low-power state |
| kirq | output | 1 | Host interrupt, outbound byte ready |
| ibf_irq | output | 1 | Processor interrupt, inbound byte ready |
| wake_req | output | 1 | One-cycle wake pulse for a stopped processor |

## Verification
The assertions take each host strobe to be a single-cycle pulse, with read and write never high together. They also take the processor to raise at most one of its three write strobes per cycle. Same-cycle collisions between the two sides are allowed and are resolved by R4 and R6. The random stimulus draws a host operation and a processor operation each cycle from mutually exclusive choices, so it stays inside these limits. The directed cases then force the collisions and the writes to the ignored status bits on purpose.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int STAT_W  = 8;
  localparam int OBF_POS = 0;
  localparam int IBF_POS = 1;
  localparam int CD_POS  = 3;

  typedef struct packed {
    logic wr_evt;
    logic out_rd;
    logic stat_rd;
    logic addr;
  } host_evt_t;

  function automatic logic [STAT_W-1:0] free_mask();
    logic [STAT_W-1:0] m;
    m = '1;
    m[OBF_POS] = 1'b0;
    m[IBF_POS] = 1'b0;
    m[CD_POS]  = 1'b0;
    return m;
  endfunction

  function automatic logic [STAT_W-1:0] stat_pack(
    input logic [STAT_W-1:0] free_bits,
    input logic cd, input logic ibf, input logic obf);
    logic [STAT_W-1:0] s;
    s = free_bits & free_mask();
    s[CD_POS]  = cd;
    s[IBF_POS] = ibf;
    s[OBF_POS] = obf;
    return s;
  endfunction

  function automatic logic [STAT_W-1:0] free_merge(
    input logic [STAT_W-1:0] old_bits, input logic [STAT_W-1:0] wr_bits);
    return (old_bits & ~free_mask()) | (wr_bits & free_mask());
  endfunction
endpackage

// File: rtl/kbc_host_port.sv
module kbc_host_port
  import kbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_cs,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic                 host_addr,
  input  logic [DATA_W-1:0]    out_data,
  input  logic [STAT_W-1:0]    status,
  output host_evt_t            evt,
  output logic [DATA_W-1:0]    host_rdata
);
  localparam int PAD_W = (DATA_W > STAT_W) ? DATA_W - STAT_W : 0;

  always_comb begin
    evt.wr_evt  = host_cs & host_wr;
    evt.out_rd  = host_cs & host_rd & ~host_addr;
    evt.stat_rd = host_cs & host_rd &  host_addr;
    evt.addr    = host_addr;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign host_rdata = host_addr ? {{PAD_W{1'b0}}, status} : out_data;
    end else begin : g_nopad
      assign host_rdata = host_addr ? status[DATA_W-1:0] : out_data;
    end
  endgenerate

  AST_NO_EVT_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !host_cs |-> !(evt.wr_evt || evt.out_rd || evt.stat_rd)); // R11
endmodule

// File: rtl/kbc_flags.sv
module kbc_flags
  import kbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  host_evt_t            evt,
  input  logic [DATA_W-1:0]    host_wdata,
  input  logic                 cpu_in_rd,
  input  logic                 cpu_out_wr,
  input  logic                 cpu_stat_wr,
  input  logic                 cpu_ctrl_wr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    in_data,
  output logic [DATA_W-1:0]    out_data,
  output logic [STAT_W-1:0]    status,
  output logic                 kirq,
  output logic                 ibf_irq
);
  logic              ibf_q, obf_q, cd_q;
  logic [STAT_W-1:0] free_q;
  logic              kirq_en_q, ibf_en_q;
  logic              ibf_set, ibf_clr, obf_set, obf_clr;

  assign ibf_set = evt.wr_evt;
  assign ibf_clr = cpu_in_rd & ~ibf_set;
  assign obf_set = cpu_out_wr;
  assign obf_clr = evt.out_rd & ~obf_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_data <= '0;
      cd_q    <= 1'b0;
      ibf_q   <= 1'b0;
    end else begin
      if (ibf_set) begin
        in_data <= host_wdata;
        cd_q    <= evt.addr;
        ibf_q   <= 1'b1;
      end else if (ibf_clr) begin
        ibf_q   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
      obf_q    <= 1'b0;
    end else begin
      if (obf_set) begin
        out_data <= cpu_wdata;
        obf_q    <= 1'b1;
      end else if (obf_clr) begin
        obf_q    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q    <= '0;
      kirq_en_q <= 1'b0;
      ibf_en_q  <= 1'b0;
    end else begin
      if (cpu_stat_wr) free_q <= free_merge(free_q, cpu_wdata[STAT_W-1:0]);
      if (cpu_ctrl_wr) begin
        kirq_en_q <= cpu_wdata[0];
        ibf_en_q  <= cpu_wdata[1];
      end
    end
  end

  assign status  = stat_pack(free_q, cd_q, ibf_q, obf_q);
  assign kirq    = obf_q & kirq_en_q;
  assign ibf_irq = ibf_q & ibf_en_q;

  AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt.wr_evt |=> status[IBF_POS]); // R2
  AST_CD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    evt.wr_evt |=> status[CD_POS] == $past(evt.addr)); // R3
  AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_in_rd && !evt.wr_evt |=> !status[IBF_POS]); // R4
  AST_OBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_out_wr |=> status[OBF_POS]); // R5
  AST_OBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    evt.out_rd && !cpu_out_wr |=> !status[OBF_POS]); // R6
  AST_STAT_RD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stat_rd && !cpu_out_wr |=> $stable(status[OBF_POS])); // R6
  AST_KIRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[OBF_POS]) |-> !kirq); // R7
  AST_IBF_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[IBF_POS]) |-> !ibf_irq); // R8
  AST_HW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stat_wr && !evt.wr_evt && !cpu_in_rd && !cpu_out_wr && !evt.out_rd
    |=> $stable(status[CD_POS]) && $stable(status[IBF_POS]) && $stable(status[OBF_POS])); // R9
endmodule

// File: rtl/kbc_wake.sv
module kbc_wake
  import kbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  host_evt_t evt,
  input  logic      cpu_stopped,
  output logic      wake_req
);
  logic wake_hit;
  assign wake_hit = evt.wr_evt & cpu_stopped;

  always_ff @(posedge clk) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= wake_hit;
  end

  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(evt.wr_evt) && $past(cpu_stopped)); // R10
  AST_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    evt.wr_evt && !cpu_stopped |=> !wake_req); // R10
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cpu_in_rd,
  input  logic              cpu_out_wr,
  input  logic              cpu_stat_wr,
  input  logic              cpu_ctrl_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_in_data,
  output logic [STAT_W-1:0] cpu_status,
  input  logic              cpu_stopped,
  output logic              kirq,
  output logic              ibf_irq,
  output logic              wake_req
);
  host_evt_t         evt;
  logic [DATA_W-1:0] out_data;
  logic [STAT_W-1:0] status;

  kbc_host_port #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .out_data(out_data),
    .status(status), .evt(evt), .host_rdata(host_rdata));

  kbc_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .host_wdata(host_wdata),
    .cpu_in_rd(cpu_in_rd), .cpu_out_wr(cpu_out_wr),
    .cpu_stat_wr(cpu_stat_wr), .cpu_ctrl_wr(cpu_ctrl_wr),
    .cpu_wdata(cpu_wdata), .in_data(cpu_in_data), .out_data(out_data),
    .status(status), .kirq(kirq), .ibf_irq(ibf_irq));

  kbc_wake u_wake (
    .clk(clk), .rst_n(rst_n), .evt(evt), .cpu_stopped(cpu_stopped),
    .wake_req(wake_req));

  assign cpu_status = status;

  AST_HOST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_cs && host_rd && host_wr)); // R11
endmodule

// File: tb/kbc_mailbox_tb.sv
module kbc_mailbox_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic host_cs, host_rd, host_wr, host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic cpu_in_rd, cpu_out_wr, cpu_stat_wr, cpu_ctrl_wr;
  logic [7:0] cpu_wdata, cpu_in_data, cpu_status;
  logic cpu_stopped, kirq, ibf_irq, wake_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_in, m_out, m_free;
  logic m_ibf, m_obf, m_cd, m_ken, m_ien, m_wake;

  always #4 clk = ~clk;

  kbc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cpu_in_rd(cpu_in_rd), .cpu_out_wr(cpu_out_wr),
    .cpu_stat_wr(cpu_stat_wr), .cpu_ctrl_wr(cpu_ctrl_wr),
    .cpu_wdata(cpu_wdata), .cpu_in_data(cpu_in_data),
    .cpu_status(cpu_status), .cpu_stopped(cpu_stopped), .kirq(kirq),
    .ibf_irq(ibf_irq), .wake_req(wake_req));

  function automatic logic [7:0] exp_status();
    return {m_free[7:4], m_cd, m_free[2], m_ibf, m_obf};
  endfunction

  task automatic check(input logic ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    check(cpu_status == exp_status(), "R2/R3/R4/R5/R6/R9 status", cpu_status, exp_status());
    check(cpu_in_data == m_in, "R2 inbound data", cpu_in_data, m_in);
    check(host_rdata == (host_addr ? exp_status() : m_out), "R5 host read data",
          host_rdata, host_addr ? exp_status() : m_out);
    check(kirq == (m_obf & m_ken), "R7 kirq", {7'd0, kirq}, {7'd0, m_obf & m_ken});
    check(ibf_irq == (m_ibf & m_ien), "R8 ibf_irq", {7'd0, ibf_irq}, {7'd0, m_ibf & m_ien});
    check(wake_req == m_wake, "R10 wake_req", {7'd0, wake_req}, {7'd0, m_wake});
  endtask

  task automatic idle_inputs();
    host_cs = 0; host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    cpu_in_rd = 0; cpu_out_wr = 0; cpu_stat_wr = 0; cpu_ctrl_wr = 0;
    cpu_wdata = 0;
  endtask

  task automatic step();
    logic hw, hr0;
    @(posedge clk);
    hw  = host_cs & host_wr;
    hr0 = host_cs & host_rd & ~host_addr;
    m_wake = hw & cpu_stopped;
    if (hw) begin m_in = host_wdata; m_cd = host_addr; m_ibf = 1; end
    else if (cpu_in_rd) m_ibf = 0;
    if (cpu_out_wr) begin m_out = cpu_wdata; m_obf = 1; end
    else if (hr0) m_obf = 0;
    if (cpu_stat_wr) m_free = cpu_wdata & 8'hF4;
    if (cpu_ctrl_wr) begin m_ken = cpu_wdata[0]; m_ien = cpu_wdata[1]; end
    @(negedge clk);
    check_all();
    idle_inputs();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    idle_inputs();
    cpu_stopped = 0;
    rst_n = 0;
    m_in = 0; m_out = 0; m_free = 0; m_ibf = 0; m_obf = 0; m_cd = 0;
    m_ken = 0; m_ien = 0; m_wake = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(cpu_status == 8'h00, "R1 status", cpu_status, 8'h00);
    check({kirq, ibf_irq, wake_req} == 3'b000, "R1 irqs", {5'd0, kirq, ibf_irq, wake_req}, 8'h00);
    check(cpu_in_data == 8'h00, "R1 inbound", cpu_in_data, 8'h00);

    // enable both interrupts
    cpu_ctrl_wr = 1; cpu_wdata = 8'h03; step();
    // R3 command write, R2 IBF
    host_cs = 1; host_wr = 1; host_addr = 1; host_wdata = 8'hA5; step();
    check(cpu_status[3] == 1'b1, "R3 cd command", cpu_status, 8'h08);
    // R4 collision: host write + cpu read, IBF stays
    host_cs = 1; host_wr = 1; host_addr = 0; host_wdata = 8'h3C; cpu_in_rd = 1; step();
    check(cpu_status[1] == 1'b1, "R4 write wins", cpu_status, 8'h02);
    cpu_in_rd = 1; step();
    check(ibf_irq == 1'b0, "R8 ibf_irq drops", {7'd0, ibf_irq}, 8'h00);
    // R9 status write of all ones touches only free bits
    cpu_stat_wr = 1; cpu_wdata = 8'hFF; step();
    check(cpu_status == 8'hF4, "R9 free bits only", cpu_status, 8'hF4);
    // R5/R7 outbound post, R6 status read keeps OBF
    cpu_out_wr = 1; cpu_wdata = 8'h5A; step();
    host_cs = 1; host_rd = 1; host_addr = 1; step();
    check(kirq == 1'b1, "R6 status read keeps obf", {7'd0, kirq}, 8'h01);
    // R6 collision: host read + cpu write keeps OBF
    host_cs = 1; host_rd = 1; host_addr = 0; cpu_out_wr = 1; cpu_wdata = 8'h77; step();
    check(cpu_status[0] == 1'b1, "R6 write wins", cpu_status, 8'h01);
    // R11 strobes without select
    host_cs = 0; host_rd = 1; host_addr = 0; step();
    host_cs = 0; host_wr = 1; host_wdata = 8'h99; cpu_stopped = 1; step();
    check(cpu_in_data == 8'h3C && !wake_req, "R11 no select", cpu_in_data, 8'h3C);
    // R6/R7 host read clears OBF and kirq
    host_cs = 1; host_rd = 1; host_addr = 0; step();
    check(kirq == 1'b0, "R7 kirq drops", {7'd0, kirq}, 8'h00);
    // R10 wake while stopped
    host_cs = 1; host_wr = 1; host_wdata = 8'h11; step();
    check(wake_req == 1'b1, "R10 wake pulse", {7'd0, wake_req}, 8'h01);
    step();
    check(wake_req == 1'b0, "R10 one cycle", {7'd0, wake_req}, 8'h00);
    cpu_stopped = 0;

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int hop, cop;
      hop = $urandom_range(0, 5);
      cop = $urandom_range(0, 6);
      cpu_stopped = ($urandom_range(0, 3) == 0);
      host_addr = $urandom_range(0, 1);
      host_wdata = 8'($urandom);
      cpu_wdata = 8'($urandom);
      host_cs = (hop != 0);
      host_rd = (hop == 1 || hop == 2);
      host_wr = (hop == 3 || hop == 4);
      if (hop == 5) begin host_cs = 0; host_wr = 1; end
      cpu_in_rd   = (cop == 1 || cop == 5);
      cpu_out_wr  = (cop == 2);
      cpu_stat_wr = (cop == 3);
      cpu_ctrl_wr = (cop == 4 || cop == 5);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule